// File: doc/BRIEF.md
# Serial Port Peripheral with Fast Simulation Mode

This block is a byte-wide asynchronous serial port that sits on an APB slave port inside a 4 KB address window. Software writes a byte into a one-entry transmit holding register. The transmitter moves that byte into its shift register and sends it as a frame on the `txd` pin. Bytes arriving on the `rxd` pin are rebuilt by a receiver and placed in a one-entry receive holding register. A flags register lets software poll both holding registers.

A mode register turns the transmitter and receiver on, enables their interrupts and selects a fast test mode. In fast mode every transmitted bit lasts one clock regardless of the divisor, so a simulated program that prints text completes in a few cycles per character. The divisor register sets the number of clock cycles per serial bit. The interrupt location reads as status and is written as a write-one-to-clear mask.

Top module: `apb_uart_lite`

## Requirements
- R1: After reset, `txd` is high, both interrupt outputs are low, and the registers FLAGS (0x004), MODE (0x008), IRQ (0x00C) and DIVISOR (0x010) read as zero.
- R2: A write to HOLD (0x000) puts `pwdata[7:0]` into the transmit holding register. FLAGS bit 0 reads 1 from that write until the byte moves into the transmit shifter. A HOLD write while FLAGS bit 0 is 1 is ignored.
- R3: When MODE bit 0 (transmit enable) is 1, each byte is sent as a low start bit, eight data bits LSB first and a high stop bit. Each bit lasts DIVISOR cycles, and a DIVISOR of 0 acts as 1. When MODE bit 0 is 0, the held byte stays held and `txd` stays high.
- R4: When MODE bit 6 is 1, each transmitted bit lasts exactly one clock whatever DIVISOR holds. A MODE value of 0x41 therefore gives fast transmit with the receiver off.
- R5: When MODE bit 1 (receive enable) is 1, a correctly framed byte on `rxd`, sent with bits of DIVISOR cycles, sets FLAGS bit 1. A read of HOLD returns the byte in bits 7:0 and clears FLAGS bit 1. When MODE bit 1 is 0, traffic on `rxd` is ignored.
- R6: `rxd` passes through a two-stage synchroniser and is sampled at mid-bit. A start edge that is no longer low at mid-bit is discarded. A frame whose stop bit samples low is dropped. The receiver then accepts the next good frame.
- R7: IRQ bit 0 (mirrored on `irq_tx`) sets when the transmit holding register empties while MODE bit 2 is 1. IRQ bit 1 (mirrored on `irq_rx`) sets when a byte arrives while MODE bit 3 is 1. With the enable bit at 0, the status bit stays 0.
- R8: Writing IRQ clears each status bit written as 1 and leaves bits written as 0. Reads of IRQ change nothing, and IRQ writes change no other register.
- R9: MODE reads back only bits 0, 1, 2, 3 and 6. DIVISOR reads back its 20 bits. Unmapped offsets in the window read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | Byte offset in the 4 KB window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, high when idle |
| irq_tx | output | 1 | Transmit interrupt status |
| irq_rx | output | 1 | Receive interrupt status |

## Verification
The bench decodes every transmitted frame at the programmed bit period. A divisor off by one cycle, or a fast mode that still uses the divisor, shifts the mid-bit samples and garbles random bytes. It writes HOLD three times in a row during a frame: a design that let the third write overwrite the held byte would send the wrong second byte, and one that re-sent data would show an extra frame. On the receive side it sends a two-cycle start glitch and a frame with a low stop bit, then a good frame. A design without the mid-bit check or the stop check would flag a false byte, and one that locked up after an error would lose the good frame. It also writes zero bits, reads status and writes the other bit at the interrupt location, which catches clear-on-read and clear-all faults.

// File: rtl/apbu_pkg.sv
package apbu_pkg;
  // register word indices within the window (byte offset / 4)
  localparam int IDX_HOLD  = 0;
  localparam int IDX_FLAGS = 1;
  localparam int IDX_MODE  = 2;
  localparam int IDX_IRQ   = 3;
  localparam int IDX_DIV   = 4;

  // mode register bit positions
  localparam int MB_TX_EN = 0;
  localparam int MB_RX_EN = 1;
  localparam int MB_TX_IE = 2;
  localparam int MB_RX_IE = 3;
  localparam int MB_FAST  = 6;

  typedef struct packed {
    logic fast;
    logic rx_ie;
    logic tx_ie;
    logic rx_en;
    logic tx_en;
  } mode_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/apbu_tx.sv
module apbu_tx #(
  parameter int DATA_BITS = 8,
  parameter int DIV_W     = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] data,
  input  logic [DIV_W-1:0]     reload,
  output logic                 txd,
  output logic                 busy
);
  localparam int FRAME_W = DATA_BITS + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic [DIV_W-1:0]   tmr_q, tmr_d;
  logic               busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    tmr_d  = tmr_q;
    busy_d = busy_q;
    if (load) begin
      sh_d   = {1'b1, data, 1'b0};
      left_d = CNT_W'(FRAME_W);
      tmr_d  = reload;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (tmr_q == '0) begin
        if (left_q == CNT_W'(1)) begin
          busy_d = 1'b0;
        end else begin
          sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
          left_d = left_q - CNT_W'(1);
          tmr_d  = reload;
        end
      end else begin
        tmr_d = tmr_q - DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      tmr_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      tmr_q  <= tmr_d;
      busy_q <= busy_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
endmodule

// File: rtl/apbu_rx.sv
module apbu_rx
  import apbu_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int DIV_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 rxd,
  input  logic [DIV_W-1:0]     reload,
  output logic                 valid,
  output logic [DATA_BITS-1:0] rx_byte
);
  localparam int CNT_W = $clog2(DATA_BITS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rxs;
  rx_state_e              st_q, st_d;
  logic [DIV_W-1:0]       tmr_q, tmr_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [DATA_BITS-1:0]   sh_q, sh_d;
  logic                   valid_q, valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q[0] <= rxd;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end
  assign rxs = sync_q[SYNC_STAGES-1];

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    valid_d = 1'b0;
    if (!en) begin
      st_d = RX_IDLE;
    end else begin
      unique case (st_q)
        RX_IDLE: begin
          if (!rxs) begin
            st_d  = RX_START;
            tmr_d = reload >> 1;
          end
        end
        RX_START: begin
          if (tmr_q != '0) begin
            tmr_d = tmr_q - DIV_W'(1);
          end else if (!rxs) begin
            st_d  = RX_DATA;
            tmr_d = reload;
            cnt_d = '0;
          end else begin
            st_d = RX_IDLE;
          end
        end
        RX_DATA: begin
          if (tmr_q != '0) begin
            tmr_d = tmr_q - DIV_W'(1);
          end else begin
            sh_d  = {rxs, sh_q[DATA_BITS-1:1]};
            tmr_d = reload;
            if (cnt_q == CNT_W'(DATA_BITS - 1)) st_d = RX_STOP;
            else cnt_d = cnt_q + CNT_W'(1);
          end
        end
        RX_STOP: begin
          if (tmr_q != '0) begin
            tmr_d = tmr_q - DIV_W'(1);
          end else begin
            st_d    = RX_IDLE;
            valid_d = rxs;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      tmr_q   <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tmr_q   <= tmr_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      valid_q <= valid_d;
    end
  end

  assign valid   = valid_q;
  assign rx_byte = sh_q;
endmodule

// File: rtl/apbu_regs.sv
module apbu_regs
  import apbu_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DIV_W     = 20,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  input  logic                 tx_busy,
  output logic                 tx_load,
  output logic [DATA_BITS-1:0] tx_data,
  output logic [DIV_W-1:0]     tx_reload,
  output logic                 tx_en,
  output logic                 tx_full,
  output logic                 rx_en,
  input  logic                 rx_valid,
  input  logic [DATA_BITS-1:0] rx_byte,
  output logic [DIV_W-1:0]     rx_reload,
  output logic                 rx_full,
  output logic                 irq_tx,
  output logic                 irq_rx
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]     idx;
  logic                 wr, rd;
  logic                 wr_hold, wr_mode, wr_irq, wr_div, rd_hold;
  logic                 unused_bus;
  mode_t                mode_q, mode_d;
  logic [DIV_W-1:0]     div_q, div_d, base_reload;
  logic [DATA_BITS-1:0] txh_q, txh_d, rxh_q, rxh_d;
  logic                 txf_q, txf_d, rxf_q, rxf_d;
  logic                 tis_q, tis_d, ris_q, ris_d;

  assign idx        = paddr[ADDR_W-1:2];
  assign wr         = psel & penable & pwrite;
  assign rd         = psel & penable & ~pwrite;
  assign wr_hold    = wr && (idx == IDX_W'(IDX_HOLD));
  assign wr_mode    = wr && (idx == IDX_W'(IDX_MODE));
  assign wr_irq     = wr && (idx == IDX_W'(IDX_IRQ));
  assign wr_div     = wr && (idx == IDX_W'(IDX_DIV));
  assign rd_hold    = rd && (idx == IDX_W'(IDX_HOLD));
  assign unused_bus = ^{pwdata, paddr[1:0]};

  assign tx_load     = txf_q & mode_q.tx_en & ~tx_busy;
  assign base_reload = (div_q == '0) ? '0 : div_q - DIV_W'(1);

  always_comb begin
    mode_d = mode_q;
    div_d  = div_q;
    txh_d  = txh_q;
    txf_d  = txf_q;
    rxh_d  = rxh_q;
    rxf_d  = rxf_q;
    tis_d  = tis_q;
    ris_d  = ris_q;
    if (wr_mode) begin
      mode_d.tx_en = pwdata[MB_TX_EN];
      mode_d.rx_en = pwdata[MB_RX_EN];
      mode_d.tx_ie = pwdata[MB_TX_IE];
      mode_d.rx_ie = pwdata[MB_RX_IE];
      mode_d.fast  = pwdata[MB_FAST];
    end
    if (wr_div) div_d = pwdata[DIV_W-1:0];
    // transmit holding register
    if (tx_load) txf_d = 1'b0;
    if (wr_hold && !txf_q) begin
      txf_d = 1'b1;
      txh_d = pwdata[DATA_BITS-1:0];
    end
    // receive holding register: a new arrival wins over a read
    if (rd_hold) rxf_d = 1'b0;
    if (rx_valid) begin
      rxf_d = 1'b1;
      rxh_d = rx_byte;
    end
    // interrupt status: set wins over clear
    if (wr_irq && pwdata[0]) tis_d = 1'b0;
    if (wr_irq && pwdata[1]) ris_d = 1'b0;
    if (tx_load && mode_q.tx_ie) tis_d = 1'b1;
    if (rx_valid && mode_q.rx_ie) ris_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= '0;
      txh_q  <= '0;
      txf_q  <= 1'b0;
      rxh_q  <= '0;
      rxf_q  <= 1'b0;
      tis_q  <= 1'b0;
      ris_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      div_q  <= div_d;
      txh_q  <= txh_d;
      txf_q  <= txf_d;
      rxh_q  <= rxh_d;
      rxf_q  <= rxf_d;
      tis_q  <= tis_d;
      ris_q  <= ris_d;
    end
  end

  always_comb begin
    prdata = '0;
    unique case (idx)
      IDX_W'(IDX_HOLD):  prdata[DATA_BITS-1:0] = rxh_q;
      IDX_W'(IDX_FLAGS): prdata[1:0] = {rxf_q, txf_q};
      IDX_W'(IDX_MODE): begin
        prdata[MB_TX_EN] = mode_q.tx_en;
        prdata[MB_RX_EN] = mode_q.rx_en;
        prdata[MB_TX_IE] = mode_q.tx_ie;
        prdata[MB_RX_IE] = mode_q.rx_ie;
        prdata[MB_FAST]  = mode_q.fast;
      end
      IDX_W'(IDX_IRQ):   prdata[1:0] = {ris_q, tis_q};
      IDX_W'(IDX_DIV):   prdata[DIV_W-1:0] = div_q;
      default:           prdata = '0;
    endcase
  end

  assign tx_data   = txh_q;
  assign tx_reload = mode_q.fast ? '0 : base_reload;
  assign rx_reload = base_reload;
  assign tx_en     = mode_q.tx_en;
  assign rx_en     = mode_q.rx_en;
  assign tx_full   = txf_q;
  assign rx_full   = rxf_q;
  assign irq_tx    = tis_q;
  assign irq_rx    = ris_q;
endmodule

// File: rtl/apb_uart_lite.sv
module apb_uart_lite #(
  parameter int ADDR_W      = 12,
  parameter int DIV_W       = 20,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_tx,
  output logic              irq_rx
);
  logic [1:0]           rst_pipe;
  logic                 rst_n;
  logic                 tx_busy, tx_load, tx_en, tx_full;
  logic                 rx_en, rx_valid, rx_full;
  logic [DATA_BITS-1:0] tx_data, rx_byte;
  logic [DIV_W-1:0]     tx_reload, rx_reload;

  // asynchronous assertion, synchronous release
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) rst_pipe <= 2'b00;
    else          rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  apbu_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) i_regs (
    .clk(pclk), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata),
    .tx_busy(tx_busy), .tx_load(tx_load), .tx_data(tx_data),
    .tx_reload(tx_reload), .tx_en(tx_en), .tx_full(tx_full),
    .rx_en(rx_en), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_reload(rx_reload), .rx_full(rx_full),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  apbu_tx #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W)) i_tx (
    .clk(pclk), .rst_n(rst_n), .load(tx_load), .data(tx_data),
    .reload(tx_reload), .txd(txd), .busy(tx_busy)
  );

  apbu_rx #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk(pclk), .rst_n(rst_n), .en(rx_en), .rxd(rxd),
    .reload(rx_reload), .valid(rx_valid), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/apbu_checker.sv
module apbu_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic              txd,
  input logic              tx_load,
  input logic              tx_busy,
  input logic              tx_full,
  input logic              tx_en,
  input logic              rx_valid,
  input logic              rx_full,
  input logic              irq_tx,
  input logic              irq_rx
);
  logic clr_wr;
  assign clr_wr = psel && penable && pwrite && (paddr[ADDR_W-1:2] == (ADDR_W-2)'(3));

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (!txd && tx_busy)); // R3
  AST_NO_LOAD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_load); // R3
  AST_HOLD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_full); // R2
  AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_full); // R5
  AST_TX_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> $past(tx_load)); // R7
  AST_RX_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> $past(rx_valid)); // R7
  AST_TX_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_tx) |-> $past(clr_wr && pwdata[0])); // R8
  AST_RX_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_rx) |-> $past(clr_wr && pwdata[1])); // R8
endmodule

bind apb_uart_lite apbu_checker #(.ADDR_W(ADDR_W)) i_apbu_checker (
  .clk(pclk), .rst_n(rst_n),
  .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
  .txd(txd), .tx_load(tx_load), .tx_busy(tx_busy), .tx_full(tx_full), .tx_en(tx_en),
  .rx_valid(rx_valid), .rx_full(rx_full), .irq_tx(irq_tx), .irq_rx(irq_rx)
);

// File: tb/test_apb_uart_lite.sv
`timescale 1ns/1ps
module test_apb_uart_lite;
  logic        pclk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        rxd;
  logic        txd, irq_tx, irq_rx;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  localparam logic [11:0] A_HOLD = 12'h000, A_FLAGS = 12'h004, A_MODE = 12'h008,
                          A_IRQ = 12'h00C, A_DIV = 12'h010;

  always #10 pclk = ~pclk;

  apb_uart_lite i_apb_uart_lite (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rxd(rxd), .txd(txd),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  function automatic int bit_period(input int div, input bit fast);
    if (fast) return 1;
    return (div == 0) ? 1 : div;
  endfunction

  function automatic logic [31:0] mode_readback(input logic [31:0] w);
    return w & 32'h0000_004F;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1'b1;
    @(negedge pclk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge pclk); penable = 1'b1; #1 d = prdata;
    @(negedge pclk); psel = 1'b0; penable = 1'b0;
  endtask

  // waits for a start bit, then samples every bit at its middle
  task automatic tx_capture(input int p, output logic [7:0] b, output logic frame_ok);
    int guard = 0;
    int pos = 0;
    logic [9:0] fr;
    @(negedge pclk);
    while (txd !== 1'b0 && guard < 20000) begin
      @(negedge pclk); guard++;
    end
    for (int k = 0; k < 10; k++) begin
      int target = k * p + p / 2;
      repeat (target - pos) @(negedge pclk);
      pos = target;
      fr[k] = txd;
    end
    b = fr[8:1];
    frame_ok = (fr[0] === 1'b0) && (fr[9] === 1'b1) && (guard < 20000);
  endtask

  task automatic rx_send(input logic [7:0] b, input int p, input logic stop_v);
    logic [9:0] fr;
    fr = {stop_v, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      @(negedge pclk); rxd = fr[k];
      repeat (p - 1) @(negedge pclk);
    end
    @(negedge pclk); rxd = 1'b1;
    repeat (2 * p) @(negedge pclk);
  endtask

  task automatic count_tx_lows(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge pclk);
      if (txd !== 1'b1) lows++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge pclk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic [7:0]  cb, b0, b1, b2;
    logic        ok, ok1;
    int          lows, dv, p;
    bit          fast;
    void'($urandom(32'd20240607));
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    rxd = 1'b1; presetn = 1'b0;
    repeat (5) @(negedge pclk);
    presetn = 1'b1;
    repeat (4) @(negedge pclk);

    // R1 reset state
    chk("R1 txd idle", {31'd0, txd}, 32'd1);
    chk("R1 irq outputs", {30'd0, irq_rx, irq_tx}, 32'd0);
    apb_rd(A_FLAGS, rv); chk("R1 FLAGS", rv, 32'd0);
    apb_rd(A_MODE, rv);  chk("R1 MODE", rv, 32'd0);
    apb_rd(A_IRQ, rv);   chk("R1 IRQ", rv, 32'd0);
    apb_rd(A_DIV, rv);   chk("R1 DIVISOR", rv, 32'd0);

    // R9 readback and decode
    apb_wr(A_MODE, 32'hFFFF_FFFF);
    apb_rd(A_MODE, rv); chk("R9 MODE mask", rv, mode_readback(32'hFFFF_FFFF));
    apb_wr(A_MODE, 32'h0);
    rv = $urandom();
    apb_wr(A_DIV, rv);
    apb_rd(A_DIV, rv); chk("R9 DIVISOR width", rv, rv & 32'h000F_FFFF);
    apb_rd(12'h014, rv); chk("R9 unmapped 0x014", rv, 32'd0);
    apb_rd(12'hFFC, rv); chk("R9 unmapped 0xFFC", rv, 32'd0);

    // R3 transmit disabled holds the byte
    apb_wr(A_DIV, 32'd4);
    apb_wr(A_HOLD, 32'hFFFF_FFA5);
    count_tx_lows(40, lows);
    chk("R3 txd quiet when disabled", lows, 32'd0);
    apb_rd(A_FLAGS, rv); chk("R2 FLAGS full while disabled", rv, 32'd1);
    fork
      tx_capture(4, cb, ok);
      apb_wr(A_MODE, 32'h01);
    join
    chk("R3 byte after enable", {24'd0, cb}, 32'hA5);
    chk("R3 frame bits after enable", {31'd0, ok}, 32'd1);
    apb_rd(A_FLAGS, rv); chk("R2 FLAGS empty after send", rv, 32'd0);

    // R4 directed fast mode with a large divisor
    apb_wr(A_DIV, 32'd16);
    apb_wr(A_MODE, 32'h41);
    fork
      tx_capture(1, cb, ok);
      apb_wr(A_HOLD, 32'h3C);
    join
    chk("R4 fast byte", {24'd0, cb}, 32'h3C);
    chk("R4 fast frame", {31'd0, ok}, 32'd1);

    // R3 R4 random transmit
    for (int i = 0; i < 12; i++) begin
      dv = $urandom_range(0, 12);
      fast = 1'($urandom_range(0, 1));
      p = bit_period(dv, fast);
      b0 = 8'($urandom());
      apb_wr(A_DIV, dv);
      apb_wr(A_MODE, fast ? 32'h41 : 32'h01);
      fork
        tx_capture(p, cb, ok);
        apb_wr(A_HOLD, {24'hABCDEF, b0});
      join
      chk(fast ? "R4 random byte" : "R3 random byte", {24'd0, cb}, {24'd0, b0});
      chk(fast ? "R4 random frame" : "R3 random frame", {31'd0, ok}, 32'd1);
    end
    repeat (20) @(negedge pclk);

    // R2 back-to-back writes, third one dropped
    apb_wr(A_DIV, 32'd8);
    apb_wr(A_MODE, 32'h01);
    b0 = 8'h96; b1 = 8'h4B; b2 = 8'hE1;
    fork
      begin
        tx_capture(8, cb, ok);
        chk("R2 first byte", {24'd0, cb}, {24'd0, b0});
        tx_capture(8, cb, ok1);
        chk("R2 second byte", {24'd0, cb}, {24'd0, b1});
        chk("R2 frames framed", {30'd0, ok, ok1}, 32'd3);
      end
      begin
        apb_wr(A_HOLD, b0);
        apb_rd(A_FLAGS, rv); chk("R2 FLAGS empty after handoff", rv, 32'd0);
        apb_wr(A_HOLD, b1);
        apb_rd(A_FLAGS, rv); chk("R2 FLAGS full while busy", rv, 32'd1);
        apb_wr(A_HOLD, b2);
      end
    join
    count_tx_lows(150, lows);
    chk("R2 no third frame", lows, 32'd0);

    // R5 R7 receive with interrupt
    apb_wr(A_DIV, 32'd16);
    apb_wr(A_MODE, 32'h0A);
    rx_send(8'h5D, 16, 1'b1);
    chk("R7 irq_rx set", {31'd0, irq_rx}, 32'd1);
    apb_rd(A_FLAGS, rv); chk("R5 FLAGS rx full", rv, 32'd2);
    apb_rd(A_IRQ, rv);   chk("R7 IRQ rx bit", rv, 32'd2);
    apb_rd(A_HOLD, rv);  chk("R5 received byte", rv, 32'h5D);
    apb_rd(A_FLAGS, rv); chk("R5 FLAGS cleared by read", rv, 32'd0);
    apb_wr(A_IRQ, 32'h2);
    chk("R8 irq_rx cleared", {31'd0, irq_rx}, 32'd0);

    // R5 R7 random receive without interrupt enable
    apb_wr(A_MODE, 32'h02);
    for (int i = 0; i < 8; i++) begin
      dv = $urandom_range(6, 16);
      b0 = 8'($urandom());
      apb_wr(A_DIV, dv);
      rx_send(b0, dv, 1'b1);
      apb_rd(A_HOLD, rv); chk("R5 random received byte", rv, {24'd0, b0});
    end
    chk("R7 irq_rx stays low when disabled", {31'd0, irq_rx}, 32'd0);

    // R5 receiver disabled
    apb_wr(A_DIV, 32'd16);
    apb_wr(A_MODE, 32'h00);
    rx_send(8'h77, 16, 1'b1);
    apb_rd(A_FLAGS, rv); chk("R5 rx ignored when disabled", rv, 32'd0);

    // R6 glitch and bad stop bit
    apb_wr(A_MODE, 32'h02);
    @(negedge pclk); rxd = 1'b0;
    repeat (2) @(negedge pclk);
    rxd = 1'b1;
    repeat (64) @(negedge pclk);
    apb_rd(A_FLAGS, rv); chk("R6 start glitch rejected", rv, 32'd0);
    rx_send(8'h3C, 16, 1'b0);
    repeat (32) @(negedge pclk);
    apb_rd(A_FLAGS, rv); chk("R6 low stop dropped", rv, 32'd0);
    rx_send(8'hC3, 16, 1'b1);
    apb_rd(A_HOLD, rv); chk("R6 recovery byte", rv, 32'hC3);

    // R7 R8 transmit interrupt
    apb_wr(A_DIV, 32'd2);
    apb_wr(A_MODE, 32'h05);
    fork
      tx_capture(2, cb, ok);
      apb_wr(A_HOLD, 32'h55);
    join
    chk("R7 irq_tx set on empty", {31'd0, irq_tx}, 32'd1);
    apb_rd(A_IRQ, rv); chk("R7 IRQ tx bit", rv, 32'd1);
    apb_rd(A_IRQ, rv); chk("R8 read does not clear", rv, 32'd1);
    apb_wr(A_IRQ, 32'h2);
    chk("R8 other bit leaves tx", {31'd0, irq_tx}, 32'd1);
    apb_rd(A_MODE, rv); chk("R8 MODE untouched", rv, 32'h05);
    apb_wr(A_IRQ, 32'h1);
    chk("R8 irq_tx cleared", {31'd0, irq_tx}, 32'd0);
    apb_wr(A_MODE, 32'h01);
    fork
      tx_capture(2, cb, ok);
      apb_wr(A_HOLD, 32'hAA);
    join
    chk("R7 irq_tx low without enable", {31'd0, irq_tx}, 32'd0);
    chk("R3 byte with irq off", {24'd0, cb}, 32'hAA);

    repeat (10) @(negedge pclk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule